// File: doc/BRIEF.md
# Bidirectional Overcurrent Window Monitor

This block protects a half-bridge power stage. It reads a signed, digitized sample of the switch-node voltage on every clock and acts on it only while the low-side switch conducts. During conduction the switch's on-resistance works as a current shunt. A sample above the upper trip limit means that current is being sunk from the load. A sample below the lower trip limit means that current is being sourced into a short. Either case is an overcurrent.

Each low-side turn-on starts a fixed blanking window that hides switching ringing. After the window ends, a trip condition is reported only when it persists for a run of consecutive clocks. A reported fault drives an active-low output. That output is held for a guaranteed minimum number of cycles, so a slower controller polling the line cannot miss the event. At 200 MHz the defaults give 40 cycles of blanking, an 8-cycle persistence filter and a 20-cycle minimum fault width.

Top module: `ocwin_monitor`

## Requirements
- R1: While `rst_n` is low, `fault_n` is 1. The blanking window starts expired, so with `lo_on` held at 1 through reset a trip condition present from release drives `fault_n` low after the 8th edge following release.
- R2: On an edge where `lo_on` is 0, the sample is not evaluated: that edge cannot start a fault and it clears the persistence run.
- R3: Upper trip: `sample > thr_hi` (signed two's-complement compare) qualifies. A sample equal to `thr_hi` does not. A fault is signalled by `fault_n = 0`.
- R4: Lower trip: `sample < thr_lo` (signed) qualifies. The upper and lower conditions are ORed.
- R5: An edge where `lo_on` is 1 and was 0 at the previous edge starts a blanking window. That edge and the next 39 edges are not evaluated. With a trip present throughout, `fault_n` goes low after the 48th edge counted from the rising one. An on-time shorter than the window produces no fault.
- R6: Blanking restarts on every rising edge of `lo_on`, including one that follows a single low cycle.
- R7: A fault is reported only on the 8th consecutive evaluated qualifying edge. A run of 7 that is broken by one non-qualifying edge clears the count.
- R8: Once asserted, `fault_n` stays low for at least 20 cycles. A trip that lasts exactly 8 edges gives a low pulse of exactly 20 cycles.
- R9: If the trip persists past the minimum width, `fault_n` stays low until the first edge without a qualified detection. A 40-edge trip gives 33 low cycles.
- R10: If `thr_hi <= thr_lo`, every evaluated edge qualifies, whatever the sample (this includes equal thresholds).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 200 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lo_on | input | 1 | 1 while the low-side switch is commanded on |
| sample | input | 12 | Signed switch-node voltage sample |
| thr_hi | input | 12 | Signed upper trip limit |
| thr_lo | input | 12 | Signed lower trip limit |
| fault_n | output | 1 | Active-low overcurrent flag |

## Verification
The hardest case to reach is a restart of blanking that hides an otherwise valid trip. This needs a long on-period, a single-cycle drop of `lo_on`, and then a trip timed to end just before the restarted window and filter would expire. The stimulus therefore builds the on/off pattern with cycle-exact lengths: 45 qualifying cycles after a one-cycle gap must stay silent, and a few more must trip. A behavioural model compares the output on every clock.

// File: rtl/ocwin_pkg.sv
package ocwin_pkg;
  // Default geometry at a 200 MHz clock
  localparam int DEF_SAMPLE_W  = 12;
  localparam int DEF_BLANK_CYC = 40;
  localparam int DEF_FILT_CYC  = 8;
  localparam int DEF_MINW_CYC  = 20;

  typedef enum logic {
    FLT_IDLE = 1'b0,
    FLT_HOLD = 1'b1
  } flt_state_e;
endpackage

// File: rtl/ocwin_blank.sv
module ocwin_blank #(
  parameter int BLANK_CYC = ocwin_pkg::DEF_BLANK_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_on,
  output logic eval_en
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC - 1);

  logic          lo_q, lo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise    = lo_on & ~lo_q;
  assign eval_en = lo_on & ~rise & (cnt_q == '0);

  always_comb begin
    lo_d  = lo_on;
    cnt_d = cnt_q;
    if (rise)
      cnt_d = LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  // Previous-enable flag resets to 1 so blanking starts expired
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      lo_q  <= lo_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ocwin_qual.sv
module ocwin_qual #(
  parameter int SAMPLE_W = ocwin_pkg::DEF_SAMPLE_W,
  parameter int FILT_CYC = ocwin_pkg::DEF_FILT_CYC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eval_en,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] thr_hi,
  input  logic signed [SAMPLE_W-1:0] thr_lo,
  output logic                       detect
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] TOP = CW'(FILT_CYC - 1);

  logic          above, below, inverted, trip, qual;
  logic [CW-1:0] run_q, run_d;

  assign above    = sample > thr_hi;
  assign below    = sample < thr_lo;
  assign inverted = thr_hi <= thr_lo;
  assign trip     = above | below | inverted;
  assign qual     = eval_en & trip;
  assign detect   = qual & (run_q == TOP);

  always_comb begin
    run_d = '0;
    if (qual)
      run_d = (run_q == TOP) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else
      run_q <= run_d;
  end
endmodule

// File: rtl/ocwin_stretch.sv
module ocwin_stretch #(
  parameter int MINW_CYC = ocwin_pkg::DEF_MINW_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic detect,
  output logic fault_n
);
  import ocwin_pkg::*;

  localparam int CW = $clog2(MINW_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(MINW_CYC - 1);

  flt_state_e    st_q, st_d;
  logic [CW-1:0] wait_q, wait_d;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    case (st_q)
      FLT_IDLE: begin
        if (detect) begin
          st_d   = FLT_HOLD;
          wait_d = LOAD;
        end
      end
      FLT_HOLD: begin
        if (wait_q != '0)
          wait_d = wait_q - 1'b1;
        else if (!detect)
          st_d = FLT_IDLE;
      end
      default: st_d = FLT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FLT_IDLE;
      wait_q <= '0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
    end
  end

  assign fault_n = (st_q != FLT_HOLD);
endmodule

// File: rtl/ocwin_monitor.sv
module ocwin_monitor #(
  parameter int SAMPLE_W  = ocwin_pkg::DEF_SAMPLE_W,
  parameter int BLANK_CYC = ocwin_pkg::DEF_BLANK_CYC,
  parameter int FILT_CYC  = ocwin_pkg::DEF_FILT_CYC,
  parameter int MINW_CYC  = ocwin_pkg::DEF_MINW_CYC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lo_on,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic signed [SAMPLE_W-1:0] thr_hi,
  input  logic signed [SAMPLE_W-1:0] thr_lo,
  output logic                       fault_n
);
  logic eval_en;
  logic detect;

  ocwin_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_on   (lo_on),
    .eval_en (eval_en)
  );

  ocwin_qual #(.SAMPLE_W(SAMPLE_W), .FILT_CYC(FILT_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval_en (eval_en),
    .sample  (sample),
    .thr_hi  (thr_hi),
    .thr_lo  (thr_lo),
    .detect  (detect)
  );

  ocwin_stretch #(.MINW_CYC(MINW_CYC)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .detect  (detect),
    .fault_n (fault_n)
  );
endmodule

// File: rtl/ocwin_monitor_chk.sv
module ocwin_monitor_chk #(
  parameter int SAMPLE_W = ocwin_pkg::DEF_SAMPLE_W,
  parameter int FILT_CYC = ocwin_pkg::DEF_FILT_CYC,
  parameter int MINW_CYC = ocwin_pkg::DEF_MINW_CYC
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lo_on,
  input logic signed [SAMPLE_W-1:0] sample,
  input logic signed [SAMPLE_W-1:0] thr_hi,
  input logic signed [SAMPLE_W-1:0] thr_lo,
  input logic                       fault_n
);
  logic        hit;
  logic [15:0] run_c;
  logic [15:0] low_c;

  assign hit = (sample > thr_hi) | (sample < thr_lo) | (thr_hi <= thr_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_c <= '0;
      low_c <= '0;
    end else begin
      run_c <= (lo_on && hit) ? ((run_c == 16'hFFFF) ? run_c : run_c + 1'b1) : '0;
      low_c <= !fault_n ? ((low_c == 16'hFFFF) ? low_c : low_c + 1'b1) : '0;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_idle_chk: assert (fault_n);
  end

  // R2
  fault_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(lo_on));

  // R7
  fault_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> (run_c >= 16'(FILT_CYC)));

  // R8
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> (low_c >= 16'(MINW_CYC)));
endmodule

bind ocwin_monitor ocwin_monitor_chk #(
  .SAMPLE_W (SAMPLE_W),
  .FILT_CYC (FILT_CYC),
  .MINW_CYC (MINW_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lo_on   (lo_on),
  .sample  (sample),
  .thr_hi  (thr_hi),
  .thr_lo  (thr_lo),
  .fault_n (fault_n)
);

// File: tb/ocwin_monitor_tb.sv
module ocwin_monitor_tb;
  localparam int BLANK = 40;
  localparam int FILT  = 8;
  localparam int MINW  = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lo_on = 1'b0;
  logic signed [11:0] sample = '0;
  logic signed [11:0] thr_hi = 12'sd200;
  logic signed [11:0] thr_lo = -12'sd200;
  logic              fault_n;

  int    checks = 0;
  int    failures = 0;
  int    low_cnt = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_lo_prev = 1'b1;
  bit m_fault = 1'b0;
  int m_blank = 0;
  int m_run = 0;
  int m_wait = 0;

  always #2.5 clk = ~clk;

  ocwin_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .lo_on(lo_on), .sample(sample),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .fault_n(fault_n)
  );

  always @(posedge clk) begin
    bit rise, ok, cond, det;
    cycles++;
    if (!rst_n) begin
      m_lo_prev = 1'b1; m_fault = 1'b0; m_blank = 0; m_run = 0; m_wait = 0;
    end else begin
      rise = lo_on && !m_lo_prev;
      ok   = lo_on && !rise && (m_blank == 0);
      if (rise) m_blank = BLANK - 1;
      else if (m_blank > 0) m_blank--;
      m_lo_prev = lo_on;
      cond = (int'(sample) > int'(thr_hi)) || (int'(sample) < int'(thr_lo)) ||
             (int'(thr_hi) <= int'(thr_lo));
      if (ok && cond) m_run++; else m_run = 0;
      det = ok && cond && (m_run >= FILT);
      if (!m_fault) begin
        if (det) begin m_fault = 1'b1; m_wait = MINW - 1; end
      end else if (m_wait > 0) m_wait--;
      else if (!det) m_fault = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: compare at negedge, then drive next inputs
  task automatic step(input logic l, input logic signed [11:0] s);
    @(negedge clk);
    check(fault_n == !m_fault, cur_req, int'(fault_n), int'(!m_fault));
    if (!fault_n) low_cnt++;
    lo_on  = l;
    sample = s;
  endtask

  task automatic run(input int n, input logic l, input logic signed [11:0] s);
    for (int i = 0; i < n; i++) step(l, s);
  endtask

  initial begin
    while (cycles < 50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset with trip present and enable high; no blanking after release
    cur_req = "R1";
    lo_on = 1'b1; sample = 12'sd300;
    run(3, 1'b1, 12'sd300);
    @(negedge clk);
    check(fault_n == 1'b1, "R1", int'(fault_n), 1);
    rst_n = 1'b1;
    run(12, 1'b1, 12'sd300);
    // R2: enable off, large sample ignored
    cur_req = "R2";
    run(40, 1'b0, 12'sd300);
    low_cnt = 0;
    run(10, 1'b0, -12'sd900);
    check(low_cnt == 0, "R2", low_cnt, 0);
    // R3: equal to upper limit does not trip, one above does
    cur_req = "R3";
    run(45, 1'b1, 12'sd0);
    low_cnt = 0;
    run(12, 1'b1, 12'sd200);
    check(low_cnt == 0, "R3", low_cnt, 0);
    run(10, 1'b1, 12'sd201);
    run(30, 1'b1, 12'sd0);
    check(low_cnt == 20, "R3", low_cnt, 20);
    // R4: lower limit
    cur_req = "R4";
    low_cnt = 0;
    run(10, 1'b1, -12'sd201);
    run(30, 1'b1, 12'sd0);
    check(low_cnt == 20, "R4", low_cnt, 20);
    // R7: broken runs of 7 never trip
    cur_req = "R7";
    low_cnt = 0;
    run(7, 1'b1, 12'sd300);
    run(1, 1'b1, 12'sd0);
    run(7, 1'b1, -12'sd300);
    run(5, 1'b1, 12'sd0);
    check(low_cnt == 0, "R7", low_cnt, 0);
    // R8: exactly 8 qualifying edges -> 20-cycle pulse
    cur_req = "R8";
    low_cnt = 0;
    run(8, 1'b1, 12'sd300);
    run(25, 1'b1, 12'sd0);
    check(low_cnt == 20, "R8", low_cnt, 20);
    // R9: 40-edge trip -> 33 low cycles
    cur_req = "R9";
    low_cnt = 0;
    run(40, 1'b1, 12'sd300);
    run(25, 1'b1, 12'sd0);
    check(low_cnt == 33, "R9", low_cnt, 33);
    // R5: on-time inside blanking is silent, longer on-time trips
    cur_req = "R5";
    run(5, 1'b0, 12'sd0);
    low_cnt = 0;
    run(30, 1'b1, 12'sd300);
    run(5, 1'b0, 12'sd300);
    check(low_cnt == 0, "R5", low_cnt, 0);
    run(47, 1'b1, 12'sd300);
    @(negedge clk);
    check(fault_n == 1'b1, "R5", int'(fault_n), 1);
    lo_on = 1'b1;
    @(negedge clk);
    check(fault_n == 1'b0, "R5", int'(fault_n), 0);
    run(30, 1'b0, 12'sd300);
    // R6: one-cycle drop restarts blanking
    cur_req = "R6";
    run(45, 1'b1, 12'sd0);
    run(1, 1'b0, 12'sd300);
    low_cnt = 0;
    run(46, 1'b1, 12'sd300);
    check(low_cnt == 0, "R6", low_cnt, 0);
    run(10, 1'b1, 12'sd300);
    run(30, 1'b0, 12'sd0);
    check(low_cnt > 0, "R6", low_cnt, 1);
    // R10: inverted and equal limits trip regardless of sample
    cur_req = "R10";
    thr_hi = -12'sd5; thr_lo = 12'sd5;
    low_cnt = 0;
    run(60, 1'b1, 12'sd0);
    run(30, 1'b0, 12'sd0);
    check(low_cnt > 0, "R10", low_cnt, 1);
    thr_hi = 12'sd7; thr_lo = 12'sd7;
    low_cnt = 0;
    run(60, 1'b1, 12'sd7);
    run(30, 1'b0, 12'sd7);
    check(low_cnt > 0, "R10", low_cnt, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule